// File: doc/BRIEF.md
# Interrupt enable and mask controller

This block gates interrupt requests for a small processor core. It keeps a global enable flag, one mask bit for each of three vectored maskable levels (called 7.5, 6.5 and 5.5, highest first), a pending latch for the edge-triggered 7.5 level, and a trap input that no enable or mask can block. From these it forms one prioritized request and a vector identifier, which the sequencer of the core consumes. When the sequencer takes the interrupt it pulses the acknowledge input.

The core issues commands through a one-cycle command strobe: enable, disable, read-mask, set-mask and halt. The read-mask command captures an 8-bit status word. The set-mask command takes a command byte that can reload the masks, clear the 7.5 pending latch and drive a single serial output bit. The halt command holds the block halted until an interrupt is acknowledged or reset is applied.

Top module: `ictl_top`

## Requirements
- R1: After reset the enable flag is 0, all three masks are 1, the serial output is 0, the halted output is 0, the status word is 8'h07 and no request is raised.
- R2: A command with op 1 (enable) sets the enable flag and op 2 (disable) clears it, from the next clock edge. With the flag clear, no maskable level raises a request.
- R3: An acknowledge pulse clears the enable flag at the next edge. Acknowledge wins over an enable command in the same cycle.
- R4: A mask bit of 1 blocks its level. Mask bit 2 blocks 7.5, bit 1 blocks 6.5 and bit 0 blocks 5.5.
- R5: Set-mask (op 4) loads command byte bits 2..0 into the masks only when byte bit 3 is 1. Otherwise the masks are kept.
- R6: A rising edge on the 7.5 input sets its pending latch, which stays set after the input falls. The latch is cleared by an acknowledge while the vector is 7.5, or by a set-mask with byte bit 4 set. A new edge in the same cycle wins over the clear.
- R7: The 6.5 and 5.5 inputs are sensed as levels and request only while they are high.
- R8: The request output is high when any source requests. The vector is 4 for trap, 3 for 7.5, 2 for 6.5, 1 for 5.5 and 0 for none, and the highest source wins.
- R9: The trap input raises a request with vector 4 whatever the enable flag and the masks hold.
- R10: Read-mask (op 3) captures the status word at the next edge. Bit 7 is the serial input, bits 6..4 are pending 7.5, 6.5 and 5.5, bit 3 is the enable flag, and bits 2..0 are the masks for 7.5, 6.5 and 5.5.
- R11: Halt (op 5) sets the halted output from the next edge. It stays set until an acknowledge, which clears it at the following edge and wins over a halt command in the same cycle.
- R12: Set-mask latches byte bit 7 into the serial output only when byte bit 6 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Command: 0 none, 1 enable, 2 disable, 3 read-mask, 4 set-mask, 5 halt |
| cmd_byte | input | 8 | Command byte for set-mask |
| serial_in | input | 1 | Serial input data bit |
| trap_in | input | 1 | Non-maskable trap request |
| lvl75_in | input | 1 | Level 7.5 input, rising-edge sensed |
| lvl65_in | input | 1 | Level 6.5 input, level sensed |
| lvl55_in | input | 1 | Level 5.5 input, level sensed |
| ack_in | input | 1 | Interrupt acknowledge pulse |
| irq_req | output | 1 | Prioritized interrupt request |
| irq_vec | output | 3 | Vector identifier of the winning source |
| status_byte | output | 8 | Status word captured by read-mask |
| serial_out | output | 1 | Serial output data bit |
| halted | output | 1 | Halt state |

## Verification
The assertions check on every cycle that trap always wins the vector, that an acknowledge leaves the enable flag clear, that a 5.5 vector appears only with the flag set and the level unmasked, and that the masks move only on a mask-loading set-mask. They also check that the halt state holds until acknowledged and that a 7.5 rising edge always reaches the pending latch. The full layout of the status word, the latch-clear paths through set-mask, the conditional serial output and the priority order among several live sources show only in the bench scenarios. There a reference model computed from the requirements is compared against the outputs under directed and random command streams.

// File: rtl/ictl_pkg.sv
package ictl_pkg;
    localparam int NLVL   = 3;
    localparam int STAT_W = 8;
    localparam int NSRC   = NLVL + 1;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_EN   = 3'd1,
        OP_DIS  = 3'd2,
        OP_RDM  = 3'd3,
        OP_SETM = 3'd4,
        OP_HALT = 3'd5
    } op_t;

    typedef struct packed {
        logic              ie;
        logic [NLVL-1:0]   mask;
        logic              sod;
        logic              halt;
        logic [STAT_W-1:0] stat;
    } ctl_st_t;
endpackage

// File: rtl/ictl_edge_latch.sv
module ictl_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic clr,
    output logic pend
);
    logic prev_d, prev_q, pend_d, pend_q;

    always_comb begin
        prev_d = lvl;
        pend_d = (lvl & ~prev_q) | (pend_q & ~clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
            pend_q <= pend_d;
        end
    end

    assign pend = pend_q;

    // R6: a rising edge always lands in the latch
    p_rise_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl && !prev_q) |=> pend);
endmodule

// File: rtl/ictl_prio.sv
module ictl_prio #(
    parameter int N = 4,
    localparam int VW = $clog2(N + 1)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [VW-1:0] vec
);
    always_comb begin
        vec = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) vec = VW'(i + 1);
        end
    end

    assign any = |req;
endmodule

// File: rtl/ictl_top.sv
module ictl_top
    import ictl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [2:0]  cmd_op,
    input  logic [7:0]  cmd_byte,
    input  logic        serial_in,
    input  logic        trap_in,
    input  logic        lvl75_in,
    input  logic        lvl65_in,
    input  logic        lvl55_in,
    input  logic        ack_in,
    output logic        irq_req,
    output logic [2:0]  irq_vec,
    output logic [7:0]  status_byte,
    output logic        serial_out,
    output logic        halted
);
    localparam int VW = $clog2(NSRC + 1);
    localparam logic [VW-1:0] VEC_TRAP = VW'(NSRC);
    localparam logic [VW-1:0] VEC_75   = VW'(NLVL);
    localparam logic [VW-1:0] VEC_55   = VW'(1);

    ctl_st_t st_d, st_q;
    logic [NSRC-1:0] req;
    logic [NLVL-1:0] lvl_pend;
    logic pend75, clr75, any;
    logic [VW-1:0] vec;
    op_t op;

    assign op = cmd_valid ? op_t'(cmd_op) : OP_NOP;
    assign clr75 = (ack_in && vec == VEC_75) || (op == OP_SETM && cmd_byte[4]);

    ictl_edge_latch u_edge75 (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (lvl75_in),
        .clr  (clr75),
        .pend (pend75)
    );

    assign lvl_pend = {pend75, lvl65_in, lvl55_in};

    genvar g;
    generate
        for (g = 0; g < NLVL; g++) begin : g_gate
            assign req[g] = st_q.ie & ~st_q.mask[g] & lvl_pend[g];
        end
    endgenerate
    assign req[NSRC-1] = trap_in;

    ictl_prio #(.N(NSRC)) u_prio (
        .req(req),
        .any(any),
        .vec(vec)
    );

    always_comb begin
        st_d = st_q;
        case (op)
            OP_EN:   st_d.ie = 1'b1;
            OP_DIS:  st_d.ie = 1'b0;
            OP_RDM:  st_d.stat = {serial_in, lvl_pend, st_q.ie, st_q.mask};
            OP_SETM: begin
                if (cmd_byte[3]) st_d.mask = cmd_byte[NLVL-1:0];
                if (cmd_byte[6]) st_d.sod  = cmd_byte[7];
            end
            OP_HALT: st_d.halt = 1'b1;
            default: ;
        endcase
        if (ack_in) begin
            st_d.ie   = 1'b0;
            st_d.halt = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ie   <= 1'b0;
            st_q.mask <= '1;
            st_q.sod  <= 1'b0;
            st_q.halt <= 1'b0;
            st_q.stat <= {{(STAT_W-NLVL){1'b0}}, {NLVL{1'b1}}};
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_req     = any;
    assign irq_vec     = vec;
    assign status_byte = st_q.stat;
    assign serial_out  = st_q.sod;
    assign halted      = st_q.halt;

    // R9: trap always owns the vector
    p_trap_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_in |-> (irq_req && irq_vec == VEC_TRAP));

    // R3: acknowledge leaves the enable flag clear
    p_ack_clears_ie_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_in |=> !st_q.ie);

    // R4: lowest level only with enable set and mask clear
    p_masked_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_vec == VEC_55) |-> (st_q.ie && !st_q.mask[0] && lvl55_in));

    // R5: masks move only on a mask-loading set-mask
    p_mask_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(op == OP_SETM && cmd_byte[3]) |=> $stable(st_q.mask));

    // R11: halt holds until acknowledged
    p_halt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !ack_in) |=> halted);
endmodule

// File: tb/tb_ictl_top.sv
module tb_ictl_top;
    import ictl_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [7:0] cmd_byte = 8'd0;
    logic       serial_in = 1'b0, trap_in = 1'b0, ack_in = 1'b0;
    logic       lvl75_in = 1'b0, lvl65_in = 1'b0, lvl55_in = 1'b0;
    logic       irq_req, serial_out, halted;
    logic [2:0] irq_vec;
    logic [7:0] status_byte;

    int total = 0;
    int bad = 0;

    logic       m_ie, m_p75, m_prev, m_sod, m_halt;
    logic [2:0] m_mask;
    logic [7:0] m_stat;

    always #5 clk = ~clk;

    ictl_top dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_byte(cmd_byte), .serial_in(serial_in), .trap_in(trap_in),
        .lvl75_in(lvl75_in), .lvl65_in(lvl65_in), .lvl55_in(lvl55_in),
        .ack_in(ack_in), .irq_req(irq_req), .irq_vec(irq_vec),
        .status_byte(status_byte), .serial_out(serial_out), .halted(halted)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] mvec();
        logic [2:0] v = 3'd0;
        if (m_ie && !m_mask[0] && lvl55_in) v = 3'd1;
        if (m_ie && !m_mask[1] && lvl65_in) v = 3'd2;
        if (m_ie && !m_mask[2] && m_p75)    v = 3'd3;
        if (trap_in)                        v = 3'd4;
        return v;
    endfunction

    task automatic model_reset();
        m_ie = 1'b0; m_p75 = 1'b0; m_prev = 1'b0; m_sod = 1'b0;
        m_halt = 1'b0; m_mask = 3'b111; m_stat = 8'h07;
    endtask

    task automatic step();
        logic [2:0] ev;
        logic       n_ie, n_p75, n_sod, n_halt, clr;
        logic [2:0] n_mask;
        logic [7:0] n_stat;
        logic [2:0] op;
        #1;
        ev = mvec();
        chk({5'd0, irq_vec}, {5'd0, ev}, trap_in ? "R9" : "R8");
        chk({7'd0, irq_req}, {7'd0, ev != 3'd0}, "R8");
        chk(status_byte, m_stat, "R10");
        chk({7'd0, halted}, {7'd0, m_halt}, "R11");
        chk({7'd0, serial_out}, {7'd0, m_sod}, "R12");
        op = cmd_valid ? cmd_op : 3'd0;
        n_ie = m_ie; n_mask = m_mask; n_sod = m_sod; n_halt = m_halt; n_stat = m_stat;
        if (op == 3'd1) n_ie = 1'b1;
        if (op == 3'd2) n_ie = 1'b0;
        if (op == 3'd3) n_stat = {serial_in, m_p75, lvl65_in, lvl55_in, m_ie, m_mask};
        if (op == 3'd4 && cmd_byte[3]) n_mask = cmd_byte[2:0];
        if (op == 3'd4 && cmd_byte[6]) n_sod = cmd_byte[7];
        if (op == 3'd5) n_halt = 1'b1;
        if (ack_in) begin n_ie = 1'b0; n_halt = 1'b0; end
        clr = (ack_in && ev == 3'd3) || (op == 3'd4 && cmd_byte[4]);
        n_p75 = (lvl75_in & ~m_prev) | (m_p75 & ~clr);
        @(posedge clk);
        m_ie = n_ie; m_mask = n_mask; m_sod = n_sod; m_halt = n_halt;
        m_stat = n_stat; m_p75 = n_p75; m_prev = lvl75_in;
        @(negedge clk);
    endtask

    task automatic cmd(input op_t o, input logic [7:0] b);
        cmd_valid = 1'b1; cmd_op = o; cmd_byte = b;
        step();
        cmd_valid = 1'b0; cmd_op = 3'd0; cmd_byte = 8'd0;
    endtask

    initial begin
        #1000000;
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7531));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(status_byte, 8'h07, "R1");
        chk({7'd0, irq_req}, 8'd0, "R1");
        chk({7'd0, serial_out}, 8'd0, "R1");
        chk({7'd0, halted}, 8'd0, "R1");
        @(negedge clk);

        lvl55_in = 1'b1;
        step(); #1; chk({7'd0, irq_req}, 8'd0, "R4");
        cmd(OP_SETM, 8'h08); #1; chk({7'd0, irq_req}, 8'd0, "R2");
        cmd(OP_EN, 8'h00); #1; chk({5'd0, irq_vec}, 8'd1, "R7");
        cmd(OP_RDM, 8'h00); #1; chk(status_byte, 8'h18, "R10");
        cmd(OP_SETM, 8'h09); #1; chk({7'd0, irq_req}, 8'd0, "R4");
        cmd(OP_SETM, 8'h08);

        lvl75_in = 1'b1; step();
        lvl75_in = 1'b0; step(); #1; chk({5'd0, irq_vec}, 8'd3, "R6");
        lvl65_in = 1'b1; step(); #1; chk({5'd0, irq_vec}, 8'd3, "R8");
        trap_in = 1'b1; cmd(OP_DIS, 8'h00); #1; chk({5'd0, irq_vec}, 8'd4, "R9");
        trap_in = 1'b0; cmd(OP_EN, 8'h00);

        ack_in = 1'b1; step(); ack_in = 1'b0;
        cmd(OP_RDM, 8'h00); #1; chk(status_byte, 8'h30, "R3");
        cmd(OP_EN, 8'h00); #1; chk({5'd0, irq_vec}, 8'd2, "R6");
        ack_in = 1'b1; cmd(OP_EN, 8'h00); ack_in = 1'b0;
        #1; chk({7'd0, irq_req}, 8'd0, "R3");

        cmd(OP_EN, 8'h00);
        lvl75_in = 1'b1; step(); lvl75_in = 1'b0;
        cmd(OP_SETM, 8'h10); #1; chk({5'd0, irq_vec}, 8'd2, "R6");
        cmd(OP_SETM, 8'h0E); #1; chk({5'd0, irq_vec}, 8'd1, "R5");
        lvl55_in = 1'b0; step(); #1; chk({7'd0, irq_req}, 8'd0, "R7");
        cmd(OP_SETM, 8'h80); #1; chk({7'd0, serial_out}, 8'd0, "R12");
        cmd(OP_SETM, 8'hC0); #1; chk({7'd0, serial_out}, 8'd1, "R12");

        cmd(OP_HALT, 8'h00); step(); step(); #1; chk({7'd0, halted}, 8'd1, "R11");
        ack_in = 1'b1; cmd(OP_HALT, 8'h00); ack_in = 1'b0;
        #1; chk({7'd0, halted}, 8'd0, "R11");

        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 9);
            cmd_valid = (r < 6);
            cmd_op = 3'($urandom_range(0, 5));
            cmd_byte = 8'($urandom());
            serial_in = 1'($urandom());
            trap_in = ($urandom_range(0, 15) == 0);
            lvl75_in = ($urandom_range(0, 3) == 0);
            lvl65_in = 1'($urandom());
            lvl55_in = 1'($urandom());
            ack_in = ($urandom_range(0, 7) == 0);
            step();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule